// File: doc/BRIEF.md
# Address-Window SPI Follow-Mode Bridge

This block lets a byte-wide host register bus drive a serial flash with no SPI engine of its own on the host side. The host loads a 32-bit target address, one byte at a time, into four address registers. It then reads or writes a data port. The bridge decodes the held address against a 4 KiB window at the top of the 32-bit space. The page hit inside that window, not any control bit, decides what the access does on the serial pins. One page releases chip select. Another page pulls chip select low and moves one byte on the wire, outbound for a write and inbound for a read. Chip select stays low between such byte accesses, so a flash command with its address, its data and its read-back is built as a run of data-port accesses closed by one release write.

A single request pulse starts every host access. The bridge answers with a one-cycle ready pulse. While the bridge works on an access it raises busy and ignores new requests. Register accesses and accesses that do not shift complete in one cycle. A byte transfer takes sixteen serial half periods plus one cycle. The serial side uses SPI mode 0: the clock idles low, data is sampled on the rising edge, and the most significant bit goes first.

The control state machine has three states. `ST_IDLE` waits for a request. `ST_SHIFT` waits for the shifter to finish a byte. `ST_DONE` raises ready for one cycle. The transitions are: IDLE→DONE for register accesses and for data-port accesses that move no byte, IDLE→SHIFT for a data-port access to the transfer page, SHIFT→DONE when the last bit has been clocked, and DONE→IDLE always.

Top module: `spibr_bridge`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, busy and ready are 0, and all four address registers read 0x00.
- R2: Host offsets 0 to 3 are read/write address registers forming the target address little-endian (offset 0 = bits 7:0, offset 3 = bits 31:24); a register access is answered by ready in the cycle after the request is taken.
- R3: A data-port (offset 4) write whose target address is 0xFFFFFExx, for any xx and any data value, sets cs_n to 1, produces no sck edge and completes as fast as a register access.
- R4: A data-port write to 0xFFFFFDxx sets cs_n to 0 and sends the written byte on MOSI, most significant bit first, with exactly 8 rising sck edges, MOSI stable at each rising edge and sck low whenever cs_n is 1.
- R5: A data-port read from 0xFFFFFDxx keeps cs_n at 0, holds MOSI at 1 for all 8 bits and returns on host_rdata, during ready, the 8 bits sampled from MISO on the rising edges, first bit as the most significant.
- R6: cs_n never rises during a run of consecutive 0xFFFFFDxx data-port accesses; only a release write raises it.
- R7: busy is 1 from the cycle after a request is taken until ready has been given; ready is a single-cycle pulse; a request made while busy is 1 is dropped and changes no register.
- R8: A data-port access outside 0xFFFFF000–0xFFFFFFFF, to any other page of the window, a read of page 0xFE, or an access to offsets 5 to 7 leaves cs_n unchanged, produces no sck edge, completes like a register access and, when a read, returns 0xFF.
- R9: With the half-period parameter set to D system clocks, a byte transfer is answered by ready 16·D+1 cycles after the cycle in which a register access would be answered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | One-cycle access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Register offset within the bridge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while host_ready is 1 |
| host_busy | output | 1 | Access in progress, requests ignored |
| host_ready | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong control state shows at the ports at once. If the machine leaves the shift state too early, ready arrives before the sixteenth sck edge, so the count of rising edges or the measured latency is off for that very access. A wrong chip-select update shows as a cs_n edge inside a command run, or as a missing release. Both are seen by the first edge counter read after the access. A decoder that takes a wrong page shows up either as sck activity after an access that should have been ignored, or as a read value other than 0xFF. A register write taken while busy shows on the next read-back of that offset.

// File: rtl/spibr_pkg.sv
package spibr_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 4;
    localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
    localparam int OFF_W      = 3;
    localparam logic [OFF_W-1:0] OFF_DATA = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } bridge_state_t;

    typedef struct packed {
        logic release_hit;
        logic xfer_hit;
    } page_hit_t;
endpackage

// File: rtl/spibr_addr_regs.sv
module spibr_addr_regs
    import spibr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     off,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [ADDR_W-1:0]    target,
    output logic [BYTE_W-1:0]    rd_byte
);
    logic [BYTE_W-1:0] bytes_q [ADDR_BYTES];

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bytes_q[g] <= '0;
            else if (wr_en && off == OFF_W'(g))
                bytes_q[g] <= wdata;
        end
        assign target[g*BYTE_W +: BYTE_W] = bytes_q[g];
    end

    always_comb begin
        rd_byte = '1;
        for (int i = 0; i < ADDR_BYTES; i++)
            if (off == OFF_W'(i))
                rd_byte = bytes_q[i];
    end
endmodule

// File: rtl/spibr_window_dec.sv
module spibr_window_dec
    import spibr_pkg::*;
#(
    parameter logic [19:0] WIN_TAG      = 20'hFFFFF,
    parameter logic [3:0]  PAGE_RELEASE = 4'hE,
    parameter logic [3:0]  PAGE_XFER    = 4'hD
) (
    input  logic [ADDR_W-1:8] page_addr,
    output page_hit_t         hit
);
    logic in_window;

    always_comb begin
        in_window       = (page_addr[31:12] == WIN_TAG);
        hit.release_hit = in_window && (page_addr[11:8] == PAGE_RELEASE);
        hit.xfer_hit    = in_window && (page_addr[11:8] == PAGE_XFER);
    end
endmodule

// File: rtl/spibr_shifter.sv
module spibr_shifter
    import spibr_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              done,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    localparam int CNT_W = $clog2(HALF_DIV + 1);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    logic              active_q;
    logic [CNT_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic              sck_q;
    logic              done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            tx_q     <= '1;
            rx_q     <= '0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !active_q) begin
                active_q <= 1'b1;
                div_q    <= '0;
                bit_q    <= '0;
                tx_q     <= tx_byte;
                sck_q    <= 1'b0;
            end else if (active_q) begin
                if (div_q == CNT_LAST) begin
                    div_q <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_q  <= {rx_q[BYTE_W-2:0], miso};
                    end else begin
                        sck_q <= 1'b0;
                        tx_q  <= {tx_q[BYTE_W-2:0], 1'b1};
                        if (bit_q == BIT_LAST) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = tx_q[BYTE_W-1];
    assign rx_byte = rx_q;
    assign done    = done_q;
endmodule

// File: rtl/spibr_bridge.sv
module spibr_bridge
    import spibr_pkg::*;
#(
    parameter int          HALF_DIV     = 2,
    parameter logic [19:0] WIN_TAG      = 20'hFFFFF,
    parameter logic [3:0]  PAGE_RELEASE = 4'hE,
    parameter logic [3:0]  PAGE_XFER    = 4'hD
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_wr,
    input  logic [2:0]  host_off,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        host_busy,
    output logic        host_ready,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    bridge_state_t     state_q, state_d;
    logic [ADDR_W-1:0] target;
    logic [BYTE_W-1:0] reg_rd;
    page_hit_t         hit;
    logic [BYTE_W-1:0] rx_byte;
    logic              shift_done;
    logic              accept;
    logic              is_reg;
    logic              is_data;
    logic              go_release;
    logic              go_xfer;
    logic              reg_wr_en;
    logic              shift_start;
    logic [BYTE_W-1:0] shift_tx;
    logic              cs_n_q;
    logic              rd_pending_q;
    logic [BYTE_W-1:0] rdata_q;

    assign accept     = host_req && (state_q == ST_IDLE);
    assign is_reg     = (host_off < OFF_W'(ADDR_BYTES));
    assign is_data    = (host_off == OFF_DATA);
    assign go_release = accept && is_data && host_wr && hit.release_hit;
    assign go_xfer    = accept && is_data && hit.xfer_hit;

    spibr_addr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .off     (host_off),
        .wdata   (host_wdata),
        .target  (target),
        .rd_byte (reg_rd)
    );

    spibr_window_dec #(
        .WIN_TAG      (WIN_TAG),
        .PAGE_RELEASE (PAGE_RELEASE),
        .PAGE_XFER    (PAGE_XFER)
    ) u_dec (
        .page_addr (target[ADDR_W-1:8]),
        .hit       (hit)
    );

    spibr_shifter #(
        .HALF_DIV (HALF_DIV)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (shift_start),
        .tx_byte (shift_tx),
        .rx_byte (rx_byte),
        .done    (shift_done),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = go_xfer ? ST_SHIFT : ST_DONE;
            ST_SHIFT: if (shift_done) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        reg_wr_en   = 1'b0;
        shift_start = 1'b0;
        shift_tx    = '1;
        host_busy   = 1'b0;
        host_ready  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                reg_wr_en   = accept && is_reg && host_wr;
                shift_start = go_xfer;
                shift_tx    = host_wr ? host_wdata : '1;
            end
            ST_SHIFT: host_busy = 1'b1;
            ST_DONE: begin
                host_busy  = 1'b1;
                host_ready = 1'b1;
            end
            default: ;
        endcase
    end

    // chip select and read-data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q       <= 1'b1;
            rd_pending_q <= 1'b0;
            rdata_q      <= '1;
        end else begin
            if (go_release)
                cs_n_q <= 1'b1;
            else if (go_xfer)
                cs_n_q <= 1'b0;

            if (accept) begin
                rd_pending_q <= go_xfer && !host_wr;
                rdata_q      <= (is_reg && !host_wr) ? reg_rd : '1;
            end else if (shift_done && rd_pending_q) begin
                rdata_q      <= rx_byte;
                rd_pending_q <= 1'b0;
            end
        end
    end

    assign spi_cs_n   = cs_n_q;
    assign host_rdata = rdata_q;
endmodule

// File: rtl/spibr_checker.sv
module spibr_checker (
    input logic clk,
    input logic rst_n,
    input logic host_busy,
    input logic host_ready,
    input logic spi_sck,
    input logic spi_cs_n
);
    // R4: no serial clock while the flash is deselected
    p_sck_low_when_deselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R8: the serial clock never runs while the bridge is idle
    p_no_sck_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> !spi_sck);

    // R7: ready is a single-cycle pulse
    p_ready_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    // R7: busy only drops right after ready
    p_busy_ends_with_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_busy) |-> $past(host_ready));

    // R6: chip select only rises at a completing access
    p_cs_rises_at_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> host_ready);

    // R4: serial clock never rises with chip select high
    p_sck_rise_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> !spi_cs_n);
endmodule

bind spibr_bridge spibr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_busy  (host_busy),
    .host_ready (host_ready),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n)
);

// File: tb/tb_spibr_bridge.sv
module tb_spibr_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int SHIFT_LAT  = 16 * DIV + 2;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_off = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       host_busy;
    logic       host_ready;
    logic       spi_sck;
    logic       spi_cs_n;
    logic       spi_mosi;
    logic       spi_miso;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // flash model
    logic [7:0] miso_byte = 8'h00;
    logic [2:0] sbit = 3'd0;
    logic [7:0] cap = 8'h00;
    int         sck_rises = 0;
    int         cs_rises = 0;
    int         mosi_moves = 0;

    assign spi_miso = miso_byte[3'd7 - sbit];

    always @(posedge spi_sck) begin
        cap <= {cap[6:0], spi_mosi};
        sck_rises++;
    end
    always @(negedge spi_sck) sbit <= sbit + 3'd1;
    always @(posedge spi_cs_n) cs_rises++;
    always @(spi_mosi) if (spi_sck) mosi_moves++;

    spibr_bridge #(.HALF_DIV(DIV)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_off   (host_off),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_busy  (host_busy),
        .host_ready (host_ready),
        .spi_sck    (spi_sck),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            checks++;
            $display("FAIL watchdog: act=%0d exp<=%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [2:0] off, input logic [7:0] wd,
                          output logic [7:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_off = off; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_ready && lat < 10000) begin
            @(negedge clk);
            lat++;
        end
        rd = host_rdata;
    endtask

    task automatic set_addr(input logic [31:0] a);
        logic [7:0] rd;
        int lat;
        for (int i = 0; i < 4; i++) access(1'b1, 3'(i), a[i*8 +: 8], rd, lat);
    endtask

    task automatic t_reset;
        logic [7:0] rd;
        int lat;
        chk("R1 cs_n", int'(spi_cs_n), 1);
        chk("R1 sck", int'(spi_sck), 0);
        chk("R1 busy", int'(host_busy), 0);
        chk("R1 ready", int'(host_ready), 0);
        for (int i = 0; i < 4; i++) begin
            access(1'b0, 3'(i), 8'h00, rd, lat);
            chk("R1 addr reg", int'(rd), 0);
        end
    endtask

    task automatic t_addr_regs;
        logic [7:0] rd;
        int lat;
        logic [31:0] a = 32'h1357_9BDF;
        for (int i = 0; i < 4; i++) begin
            access(1'b1, 3'(i), a[i*8 +: 8], rd, lat);
            chk("R2 write latency", lat, 1);
        end
        for (int i = 0; i < 4; i++) begin
            access(1'b0, 3'(i), 8'h00, rd, lat);
            chk("R2 readback", int'(rd), int'(a[i*8 +: 8]));
            chk("R2 read latency", lat, 1);
        end
    endtask

    task automatic t_release;
        logic [7:0] rd;
        int lat, e0;
        set_addr(32'hFFFF_FE37);
        e0 = sck_rises;
        access(1'b1, 3'd4, 8'h5A, rd, lat);
        chk("R3 cs_n high", int'(spi_cs_n), 1);
        chk("R3 no sck", sck_rises - e0, 0);
        chk("R3 latency", lat, 1);
    endtask

    task automatic t_write_byte;
        logic [7:0] rd;
        int lat, e0;
        set_addr(32'hFFFF_FD00);
        e0 = sck_rises;
        mosi_moves = 0;
        access(1'b1, 3'd4, 8'hA5, rd, lat);
        chk("R4 cs_n low", int'(spi_cs_n), 0);
        chk("R4 byte on mosi", int'(cap), 8'hA5);
        chk("R4 sck edges", sck_rises - e0, 8);
        chk("R4 mosi stable at sck high", mosi_moves, 0);
        chk("R9 shift latency", lat, SHIFT_LAT);
    endtask

    task automatic t_read_byte;
        logic [7:0] rd;
        int lat;
        miso_byte = 8'h3C;
        access(1'b0, 3'd4, 8'h00, rd, lat);
        chk("R5 read data", int'(rd), 8'h3C);
        chk("R5 mosi ones", int'(cap), 8'hFF);
        chk("R5 cs_n low", int'(spi_cs_n), 0);
    endtask

    task automatic t_run;
        logic [7:0] rd;
        int lat, c0;
        access(1'b1, 3'd4, 8'h00, rd, lat);
        c0 = cs_rises;
        miso_byte = 8'hC3;
        access(1'b1, 3'd4, 8'h9F, rd, lat);
        chk("R6 cmd byte", int'(cap), 8'h9F);
        access(1'b0, 3'd4, 8'h00, rd, lat);
        chk("R6 first read", int'(rd), 8'hC3);
        miso_byte = 8'h81;
        access(1'b0, 3'd4, 8'h00, rd, lat);
        chk("R6 second read", int'(rd), 8'h81);
        chk("R6 no cs rise in run", cs_rises - c0, 0);
    endtask

    task automatic t_busy_drop;
        logic [7:0] rd;
        int lat;
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_off = 3'd4; host_wdata = 8'h11;
        @(negedge clk);
        host_req = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 busy during shift", int'(host_busy), 1);
        host_req = 1'b1; host_wr = 1'b1; host_off = 3'd0; host_wdata = 8'h77;
        @(negedge clk);
        host_req = 1'b0;
        lat = 0;
        while (!host_ready && lat < 10000) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        chk("R7 ready one cycle", int'(host_ready), 0);
        chk("R7 busy cleared", int'(host_busy), 0);
        access(1'b0, 3'd0, 8'h00, rd, lat);
        chk("R7 dropped write", int'(rd), 8'h00);
    endtask

    task automatic t_ignored;
        logic [7:0] rd;
        int lat, e0;
        logic cs0;
        cs0 = spi_cs_n;
        e0 = sck_rises;
        set_addr(32'h1234_5D00);
        access(1'b1, 3'd4, 8'h66, rd, lat);
        access(1'b0, 3'd4, 8'h00, rd, lat);
        chk("R8 outside window read", int'(rd), 8'hFF);
        chk("R8 outside latency", lat, 1);
        set_addr(32'hFFFF_FC00);
        access(1'b0, 3'd4, 8'h00, rd, lat);
        chk("R8 other page read", int'(rd), 8'hFF);
        set_addr(32'hFFFF_FE00);
        access(1'b0, 3'd4, 8'h00, rd, lat);
        chk("R8 release-page read", int'(rd), 8'hFF);
        access(1'b0, 3'd6, 8'h00, rd, lat);
        chk("R8 offset 6 read", int'(rd), 8'hFF);
        chk("R8 cs unchanged", int'(spi_cs_n), int'(cs0));
        chk("R8 no sck", sck_rises - e0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_regs();
        t_release();
        t_write_byte();
        t_read_byte();
        t_run();
        t_busy_drop();
        t_ignored();
        t_release();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule